// File: doc/BRIEF.md
# GPIO Bank with Pin-Change Interrupt Detection

This block is a single bank of general-purpose pins with a word-wide register interface. Software sets the output value and the direction of each pin. It reads the pad levels after a two-flop synchronizer. It also configures pull resistors and a 3-bit drive-strength code for every pin. The block drives these settings straight to the pad ring.

Each pin has its own interrupt detector. The detector can trigger on a high level, a low level, a rising edge, a falling edge, or both edges. Detected events latch into a raw status word. A mask word gates the raw status into a masked view. Any bit set in the masked view raises one shared interrupt line. Software acknowledges events by writing ones to a clear register.

Register reads are combinational from the address. A write takes effect at the clock edge on which `regWe` is high. Every register holds one bit per pin, and pin n maps to data bit n.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0. `padOut`, `padOe`, `pullUpOn`, `pullDownOn`, the three drive-code outputs and `intrOut` are all 0.
- R2: A write to offset 0x04 sets `padOut`, and a write to offset 0x08 sets `padOe` (1 = drive). Both values read back at the same offsets.
- R3: Offset 0x00 reads the pad inputs through a two-stage synchronizer. A change on `padIn` becomes visible after the second rising clock edge, and not after the first.
- R4: With the type bit at 0x0C clear (edge detection) and the both-edges bit at 0x10 clear, a polarity bit (0x14) of 1 latches status on a rising edge, and a polarity bit of 0 latches status on a falling edge. The opposite edge latches nothing.
- R5: With the type bit clear and the both-edges bit at 0x10 set, either edge latches status. A steady input latches nothing.
- R6: With the type bit set (level detection), status is set on every cycle in which the synchronized input equals the polarity bit (1 = high, 0 = low). The both-edges bit is ignored in this mode, so status comes back immediately after a clear while the level persists.
- R7: Raw status reads at 0x1C. The mask at 0x18 enables a pin with a 1. The masked status at 0x20 reads raw AND mask, and `intrOut` is high exactly when any masked bit is set.
- R8: Writing a 1 to a bit of 0x24 clears that status bit, and writing 0 leaves it unchanged. If a new event for the same bit arrives in the cycle of the clear, the bit stays set.
- R9: The pull-enable register (0x38) turns a pin's pull resistor on. The pull-select register (0x34) then chooses pull-up (1) or pull-down (0). With the enable bit at 0, both `pullUpOn` and `pullDownOn` are 0 for that pin.
- R10: The drive code of each pin is 3 bits. Bit i is held at offset 0x58 + 4*i and drives `drvCode0`/`drvCode1`/`drvCode2`. A code of mA/2 − 1 selects 2 to 16 mA, so 16 mA is code 7 and 2 mA is code 0.
- R11: Reads of any unmapped offset (for example 0x28 or 0x64) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Write strobe for the register interface |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | PINS | Write data |
| regRdata | output | PINS | Read data for `regAddr` |
| padIn | input | PINS | Asynchronous pad inputs |
| padOut | output | PINS | Output data to pads |
| padOe | output | PINS | Output enable to pads |
| pullUpOn | output | PINS | Pull-up active per pin |
| pullDownOn | output | PINS | Pull-down active per pin |
| drvCode0 | output | PINS | Drive-code bit 0 per pin |
| drvCode1 | output | PINS | Drive-code bit 1 per pin |
| drvCode2 | output | PINS | Drive-code bit 2 per pin |
| intrOut | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its defaults: 32 pins, an 8-bit offset and a two-stage synchronizer. With those values the full register map is addressable, including the drive-code words at 0x58 to 0x60.

The two-stage synchronizer sets an exact three-edge latency from a pad change to a status bit. Because that latency is fixed, the bench can place a clear write in the very cycle a new edge is detected and check that the event is kept. It also walks every trigger mode on one pin, both for transitions that should latch and for ones that should not.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OFF_DIN    = 'h00;
  localparam int OFF_DOUT   = 'h04;
  localparam int OFF_OE     = 'h08;
  localparam int OFF_TYPE   = 'h0C;
  localparam int OFF_DUAL   = 'h10;
  localparam int OFF_POL    = 'h14;
  localparam int OFF_MASK   = 'h18;
  localparam int OFF_RAW    = 'h1C;
  localparam int OFF_MSTAT  = 'h20;
  localparam int OFF_CLR    = 'h24;
  localparam int OFF_PSEL   = 'h34;
  localparam int OFF_PEN    = 'h38;
  localparam int OFF_DRV    = 'h58;
  localparam int DRV_BITS   = 3;

  typedef enum logic [3:0] {
    RD_NONE, RD_DIN, RD_DOUT, RD_OE, RD_TYPE, RD_DUAL, RD_POL, RD_MASK,
    RD_RAW, RD_MSTAT, RD_PSEL, RD_PEN, RD_DRV0, RD_DRV1, RD_DRV2
  } rdSel_t;

  typedef struct packed {
    logic                wrOut;
    logic                wrOe;
    logic                wrType;
    logic                wrDual;
    logic                wrPol;
    logic                wrMask;
    logic                wrClr;
    logic                wrPullSel;
    logic                wrPullEn;
    logic [DRV_BITS-1:0] wrDrv;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rdSel_t            rdSel
);
  localparam int DRV_STEP = 4;

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    case (regAddr)
      ADDR_W'(OFF_DIN):   rdSel = RD_DIN;
      ADDR_W'(OFF_DOUT):  begin rdSel = RD_DOUT;  strb.wrOut     = regWe; end
      ADDR_W'(OFF_OE):    begin rdSel = RD_OE;    strb.wrOe      = regWe; end
      ADDR_W'(OFF_TYPE):  begin rdSel = RD_TYPE;  strb.wrType    = regWe; end
      ADDR_W'(OFF_DUAL):  begin rdSel = RD_DUAL;  strb.wrDual    = regWe; end
      ADDR_W'(OFF_POL):   begin rdSel = RD_POL;   strb.wrPol     = regWe; end
      ADDR_W'(OFF_MASK):  begin rdSel = RD_MASK;  strb.wrMask    = regWe; end
      ADDR_W'(OFF_RAW):   rdSel = RD_RAW;
      ADDR_W'(OFF_MSTAT): rdSel = RD_MSTAT;
      ADDR_W'(OFF_CLR):   strb.wrClr = regWe;
      ADDR_W'(OFF_PSEL):  begin rdSel = RD_PSEL;  strb.wrPullSel = regWe; end
      ADDR_W'(OFF_PEN):   begin rdSel = RD_PEN;   strb.wrPullEn  = regWe; end
      ADDR_W'(OFF_DRV):   begin rdSel = RD_DRV0;  strb.wrDrv[0]  = regWe; end
      ADDR_W'(OFF_DRV + DRV_STEP):     begin rdSel = RD_DRV1; strb.wrDrv[1] = regWe; end
      ADDR_W'(OFF_DRV + 2 * DRV_STEP): begin rdSel = RD_DRV2; strb.wrDrv[2] = regWe; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PINS       = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] padIn,
  input  logic [PINS-1:0] wdata,
  input  strobe_t         strb,
  input  rdSel_t          rdSel,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] pullUpOn,
  output logic [PINS-1:0] pullDownOn,
  output logic [PINS-1:0] drvCode0,
  output logic [PINS-1:0] drvCode1,
  output logic [PINS-1:0] drvCode2,
  output logic            intrOut,
  output logic [PINS-1:0] statusQ,
  output logic [PINS-1:0] maskQ,
  output logic [PINS-1:0] eventVec
);
  logic [PINS-1:0] outQ, oeQ, typeQ, dualQ, polQ, pselQ, penQ, prevQ;
  logic [PINS-1:0] syncQ [SYNC_DEPTH];
  logic [PINS-1:0] drvQ  [DRV_BITS];
  logic [PINS-1:0] syncVal, clrMask;

  // synchronizer chain
  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
    end
  end
  assign syncVal = syncQ[SYNC_DEPTH-1];

  // drive-code bit planes
  for (genvar b = 0; b < DRV_BITS; b++) begin : g_drv
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             drvQ[b] <= '0;
      else if (strb.wrDrv[b]) drvQ[b] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0; oeQ  <= '0; typeQ <= '0; dualQ <= '0; polQ <= '0;
      maskQ <= '0; pselQ <= '0; penQ <= '0; prevQ <= '0; statusQ <= '0;
    end else begin
      if (strb.wrOut)     outQ  <= wdata;
      if (strb.wrOe)      oeQ   <= wdata;
      if (strb.wrType)    typeQ <= wdata;
      if (strb.wrDual)    dualQ <= wdata;
      if (strb.wrPol)     polQ  <= wdata;
      if (strb.wrMask)    maskQ <= wdata;
      if (strb.wrPullSel) pselQ <= wdata;
      if (strb.wrPullEn)  penQ  <= wdata;
      prevQ   <= syncVal;
      statusQ <= (statusQ & ~clrMask) | eventVec;
    end
  end

  assign clrMask = strb.wrClr ? wdata : '0;

  // per-pin detection; new events override a same-cycle clear
  always_comb begin
    for (int p = 0; p < PINS; p++) begin
      if (typeQ[p])      eventVec[p] = (syncVal[p] == polQ[p]);
      else if (dualQ[p]) eventVec[p] = syncVal[p] ^ prevQ[p];
      else if (polQ[p])  eventVec[p] = syncVal[p] & ~prevQ[p];
      else               eventVec[p] = ~syncVal[p] & prevQ[p];
    end
  end

  assign intrOut    = |(statusQ & maskQ);
  assign padOut     = outQ;
  assign padOe      = oeQ;
  assign pullUpOn   = penQ & pselQ;
  assign pullDownOn = penQ & ~pselQ;
  assign drvCode0   = drvQ[0];
  assign drvCode1   = drvQ[1];
  assign drvCode2   = drvQ[2];

  always_comb begin
    case (rdSel)
      RD_DIN:   rdata = syncVal;
      RD_DOUT:  rdata = outQ;
      RD_OE:    rdata = oeQ;
      RD_TYPE:  rdata = typeQ;
      RD_DUAL:  rdata = dualQ;
      RD_POL:   rdata = polQ;
      RD_MASK:  rdata = maskQ;
      RD_RAW:   rdata = statusQ;
      RD_MSTAT: rdata = statusQ & maskQ;
      RD_PSEL:  rdata = pselQ;
      RD_PEN:   rdata = penQ;
      RD_DRV0:  rdata = drvQ[0];
      RD_DRV1:  rdata = drvQ[1];
      RD_DRV2:  rdata = drvQ[2];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS       = 32,
  parameter int ADDR_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PINS-1:0]   regWdata,
  output logic [PINS-1:0]   regRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   pullUpOn,
  output logic [PINS-1:0]   pullDownOn,
  output logic [PINS-1:0]   drvCode0,
  output logic [PINS-1:0]   drvCode1,
  output logic [PINS-1:0]   drvCode2,
  output logic              intrOut
);
  strobe_t         strb;
  rdSel_t          rdSel;
  logic [PINS-1:0] statusQ, maskQ, eventVec;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .strb(strb), .rdSel(rdSel)
  );

  gpio_bank_dp #(.PINS(PINS), .SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .wdata(regWdata), .strb(strb),
    .rdSel(rdSel), .rdata(regRdata), .padOut(padOut), .padOe(padOe),
    .pullUpOn(pullUpOn), .pullDownOn(pullDownOn), .drvCode0(drvCode0),
    .drvCode1(drvCode1), .drvCode2(drvCode2), .intrOut(intrOut),
    .statusQ(statusQ), .maskQ(maskQ), .eventVec(eventVec)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [PINS-1:0]   regWdata,
  input logic [PINS-1:0]   regRdata,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   pullUpOn,
  input logic [PINS-1:0]   pullDownOn,
  input logic              intrOut,
  input logic [PINS-1:0]   statusQ,
  input logic [PINS-1:0]   maskQ,
  input logic [PINS-1:0]   eventVec
);
  // R4
  status_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(eventVec)) == '0));

  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWe) && $past(regAddr) == ADDR_W'(OFF_CLR)) |->
      ((statusQ & $past(regWdata) & ~$past(eventVec)) == '0));

  // R7
  masked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_MSTAT)) |-> (regRdata == (statusQ & maskQ)));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !intrOut);

  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(OFF_OE)) |=> (padOe == $past(regWdata)));

  // R9
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pullUpOn & pullDownOn) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .padOe(padOe),
  .pullUpOn(pullUpOn), .pullDownOn(pullDownOn), .intrOut(intrOut),
  .statusQ(statusQ), .maskQ(maskQ), .eventVec(eventVec)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 32;
  localparam int AW = 8;
  localparam int PIN = 5;
  // {type, dual, pol, start, end, expectedStatus}
  localparam logic [5:0] VEC [13] = '{
    6'b001_01_1, 6'b001_10_0, 6'b000_10_1, 6'b000_01_0,
    6'b010_01_1, 6'b010_10_1, 6'b010_11_0, 6'b011_00_0,
    6'b101_01_1, 6'b101_00_0, 6'b100_10_1, 6'b100_11_0,
    6'b111_00_0
  };

  logic clk = 0, rstN = 0, regWe = 0;
  logic [AW-1:0] regAddr = '0;
  logic [PINS-1:0] regWdata = '0, regRdata, padIn = '0;
  logic [PINS-1:0] padOut, padOe, pullUpOn, pullDownOn, drvCode0, drvCode1, drvCode2;
  logic intrOut;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullUpOn(pullUpOn),
    .pullDownOn(pullDownOn), .drvCode0(drvCode0), .drvCode1(drvCode1),
    .drvCode2(drvCode2), .intrOut(intrOut)
  );

  task automatic check(string tag, logic [PINS-1:0] got, logic [PINS-1:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [PINS-1:0] d);
    @(negedge clk);
    regWe = 1; regAddr = AW'(addr); regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = '0;
  endtask

  task automatic rd(int addr, output logic [PINS-1:0] d);
    @(negedge clk);
    regAddr = AW'(addr);
    #1 d = regRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] d;
    logic [PINS-1:0] bitP;
    bitP = PINS'(1) << PIN;
    waitCyc(3);
    #1;
    // R1 reset state, checked before reset release as well
    check("R1 padOut", padOut, '0);
    check("R1 padOe", padOe, '0);
    check("R1 intrOut", {31'b0, intrOut}, '0);
    @(negedge clk) rstN = 1;
    foreach (VEC[i]) ;
    begin
      int offs [14] = '{'h00,'h04,'h08,'h0C,'h10,'h14,'h18,'h1C,'h20,'h34,'h38,'h58,'h5C,'h60};
      for (int k = 0; k < 14; k++) begin
        rd(offs[k], d);
        check($sformatf("R1 reg %h", offs[k]), d, '0);
      end
    end
    check("R1 pulls", pullUpOn | pullDownOn, '0);
    check("R1 drive", drvCode0 | drvCode1 | drvCode2, '0);

    // R2 output data and enable
    wr('h04, 32'hA5A5_0F0F);
    wr('h08, 32'h0000_FFFF);
    check("R2 padOut", padOut, 32'hA5A5_0F0F);
    check("R2 padOe", padOe, 32'h0000_FFFF);
    rd('h04, d); check("R2 read out", d, 32'hA5A5_0F0F);
    rd('h08, d); check("R2 read oe", d, 32'h0000_FFFF);

    // R3 two-stage input latency
    @(negedge clk) padIn = 32'h0000_0100;
    @(posedge clk); #1 regAddr = 'h00;
    #1 check("R3 after one edge", regRdata, '0);
    @(posedge clk); #1;
    check("R3 after two edges", regRdata, 32'h0000_0100);
    @(negedge clk) padIn = '0;
    waitCyc(4);
    wr('h24, '1);

    // R4 R5 R6 mode table walk on one pin
    for (int i = 0; i < 13; i++) begin
      logic [5:0] v;
      v = VEC[i];
      wr('h0C, v[5] ? bitP : '0);
      wr('h10, v[4] ? bitP : '0);
      wr('h14, v[3] ? bitP : '0);
      @(negedge clk) padIn = v[2] ? bitP : '0;
      waitCyc(4);
      wr('h24, '1);
      @(negedge clk) padIn = v[1] ? bitP : '0;
      waitCyc(4);
      rd('h1C, d);
      check($sformatf("R4 R5 R6 mode vector %0d", i), d & bitP, v[0] ? bitP : '0);
    end

    // return to falling edge mode, input low, clean status
    wr('h0C, '0); wr('h10, '0); wr('h14, '0);
    @(negedge clk) padIn = '0;
    waitCyc(4);
    wr('h24, '1);

    // R7 mask gating: rising edge on pin 3 with mask off
    wr('h14, 32'h8);
    @(negedge clk) padIn = 32'h8;
    waitCyc(4);
    rd('h1C, d); check("R7 raw set", d, 32'h8);
    rd('h20, d); check("R7 masked off", d, '0);
    check("R7 intr masked", {31'b0, intrOut}, '0);
    wr('h18, 32'h8);
    rd('h20, d); check("R7 masked on", d, 32'h8);
    check("R7 intr on", {31'b0, intrOut}, 32'h1);

    // R8 write of zero has no effect, write of one clears
    wr('h24, 32'hFFFF_FFF7);
    rd('h1C, d); check("R8 zero no effect", d, 32'h8);
    wr('h24, 32'h8);
    rd('h1C, d); check("R8 clear", d, '0);
    check("R8 intr drop", {31'b0, intrOut}, '0);

    // R8 new event in the clear cycle wins (dual edge on pin 3)
    wr('h10, 32'h8);
    @(negedge clk) padIn = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    regWe = 1; regAddr = AW'('h24); regWdata = 32'h8;
    @(negedge clk) regWe = 0; regWdata = '0;
    rd('h1C, d); check("R8 event beats clear", d, 32'h8);
    wr('h24, 32'h8);

    // R9 pulls
    wr('h34, 32'h0000_00F0);
    check("R9 no enable", pullUpOn | pullDownOn, '0);
    wr('h38, 32'h0000_00FF);
    check("R9 pull up", pullUpOn, 32'h0000_00F0);
    check("R9 pull down", pullDownOn, 32'h0000_000F);

    // R10 drive code: pin 2 at 16 mA (7), pin 9 at 6 mA (2), pin 0 at 2 mA (0)
    wr('h58, 32'h4);
    wr('h5C, 32'h204);
    wr('h60, 32'h4);
    check("R10 bit0", drvCode0, 32'h4);
    check("R10 bit1", drvCode1, 32'h204);
    check("R10 bit2", drvCode2, 32'h4);
    rd('h5C, d); check("R10 read bit1", d, 32'h204);
    check("R10 pin0 2mA", {29'b0, drvCode2[0], drvCode1[0], drvCode0[0]}, '0);

    // R11 unmapped offsets
    rd('h28, d); check("R11 0x28", d, '0);
    rd('h64, d); check("R11 0x64", d, '0);
    rd('h24, d); check("R11 clear reads 0", d, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule